// File: doc/BRIEF.md
# Multicycle Shared-Memory Processor Datapath

This block is the data side of a processor that spreads each instruction over several clock cycles. One memory port carries both instruction fetches and data accesses, and one ALU handles PC increment, branch-target arithmetic, address generation and register arithmetic. Values that one cycle produces and a later cycle uses are kept in internal holding registers: the instruction register, the memory data register, the two operand registers and the ALU result register.

The block decides nothing on its own. A separate sequencer supplies a set of steering and write-enable strobes every cycle. The only thing the block reports back to that sequencer is the opcode field of the held instruction. ALU operation selection is split into two levels. A 2-bit operation class comes from the sequencer. A local decoder then expands it, and for register-to-register instructions it also reads the instruction's function field. The memory itself sits outside the block. The block presents an address and write data and takes read data back in the same cycle.

Top module: `mcycle_datapath`

## Requirements
- R1: While rstN is low, and after it rises until the first clock edge, the PC, the instruction register, the memory data register, the operand registers, the ALU result register and every register-file entry read as zero. This means memAddr is 0 for either value of iorD, memWdata is 0 and opcode is 0.
- R2: A clock edge with irWrite=1 loads memRdata into the instruction register, and opcode then shows bits [31:26] of it. With aluSrcA=0 the ALU takes the PC, and aluSrcB=01 supplies the constant 4. With pcSource=00 and pcWrite=1 the PC loads the ALU result, so a fetch step advances the PC by 4.
- R3: With irWrite=0 the instruction register keeps its value, even while memRdata changes.
- R4: Each clock loads operand register A from the register-file entry indexed by instruction bits [25:21], and operand register B from the entry indexed by bits [20:16]. Entry 0 always reads as zero, and a write aimed at it has no effect.
- R5: On a clock edge with regWrite=1, the register file writes to the entry indexed by bits [15:11] when regDst=1, or by bits [20:16] when regDst=0. The data written is the memory data register when memToReg=1, or the ALU result register when memToReg=0.
- R6: aluSrcB=10 gives the ALU the sign-extended instruction bits [15:0]. aluSrcB=11 gives the same value shifted left by 2. aluSrcB=00 gives operand register B, and aluSrcA=1 gives operand register A.
- R7: With aluOp=10 the operation follows function bits [5:0]: 100000 add, 100010 subtract, 100100 bitwise AND, 100101 bitwise OR, 101010 set-on-less-than. Set-on-less-than compares as signed two's complement and returns 1 or 0 in bit 0.
- R8: aluOp=00 always adds and aluOp=01 always subtracts, whatever the function bits hold.
- R9: The PC loads on a clock edge when pcWrite=1, or when pcWriteCond=1 and the current ALU result is zero. Otherwise it holds. pcSource=01 loads the ALU result register. pcSource=10 loads {PC[31:28], instruction bits [25:0], 2'b00}.
- R10: The memory data register, both operand registers and the ALU result register load on every clock. memAddr is the PC when iorD=0 and the ALU result register when iorD=1. memWdata is operand register B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pcWrite | input | 1 | Unconditional PC load |
| pcWriteCond | input | 1 | PC load when the ALU result is zero |
| iorD | input | 1 | Memory address select: 0 PC, 1 ALU result register |
| irWrite | input | 1 | Instruction register load enable |
| regDst | input | 1 | Write index select: 1 bits [15:11], 0 bits [20:16] |
| memToReg | input | 1 | Write data select: 1 memory data register, 0 ALU result register |
| regWrite | input | 1 | Register-file write enable |
| aluSrcA | input | 1 | ALU first operand: 0 PC, 1 operand register A |
| aluSrcB | input | 2 | ALU second operand: B, 4, immediate, immediate shifted by 2 |
| aluOp | input | 2 | Operation class: 00 add, 01 subtract, 10 function field |
| pcSource | input | 2 | PC source: 00 ALU result, 01 ALU result register, 10 jump target |
| memRdata | input | 32 | Read data from the shared memory |
| memAddr | output | 32 | Shared memory byte address |
| memWdata | output | 32 | Store data (operand register B) |
| opcode | output | 6 | Bits [31:26] of the instruction register |

## Verification
The assertions assume the sequencer drives iorD low whenever the PC is to be observed on memAddr. Every PC-related property therefore treats a cycle with iorD high as uninformative, and asserts nothing about the address in that cycle. They also assume a fetch uses the complete fetch strobe set (PC into the ALU, constant 4, add, ALU result to the PC). The stimulus meets both assumptions. It steps each instruction through fetch, decode and the execute, memory and write-back steps that belong to its opcode. It raises iorD only in memory steps and in side-effect-free peeks taken between clock edges. It never combines pcWrite with pcWriteCond.

// File: rtl/mcycle_pkg.sv
package mcycle_pkg;

  localparam int XLEN = 32;

  typedef struct packed {
    logic       pcWrite;
    logic       pcWriteCond;
    logic       iorD;
    logic       irWrite;
    logic       regDst;
    logic       memToReg;
    logic       regWrite;
    logic       aluSrcA;
    logic [1:0] aluSrcB;
    logic [1:0] aluOp;
    logic [1:0] pcSource;
  } dpCtrl_t;

  typedef enum logic [2:0] {
    FN_ADD = 3'b000,
    FN_SUB = 3'b001,
    FN_SLT = 3'b010,
    FN_AND = 3'b100,
    FN_OR  = 3'b101
  } aluFn_t;

  localparam logic [1:0] OPC_ADD   = 2'b00;
  localparam logic [1:0] OPC_SUB   = 2'b01;
  localparam logic [1:0] OPC_FIELD = 2'b10;

  localparam logic [5:0] FUNCT_ADD = 6'b100000;
  localparam logic [5:0] FUNCT_SUB = 6'b100010;
  localparam logic [5:0] FUNCT_AND = 6'b100100;
  localparam logic [5:0] FUNCT_OR  = 6'b100101;
  localparam logic [5:0] FUNCT_SLT = 6'b101010;

endpackage

// File: rtl/mcycle_alu_dec.sv
module mcycle_alu_dec
  import mcycle_pkg::*;
(
  input  logic [1:0] aluOp,
  input  logic [5:0] funct,
  output aluFn_t     aluFn
);

  always_comb begin
    unique case (aluOp)
      OPC_ADD: aluFn = FN_ADD;
      OPC_SUB: aluFn = FN_SUB;
      OPC_FIELD: begin
        unique case (funct)
          FUNCT_ADD: aluFn = FN_ADD;
          FUNCT_SUB: aluFn = FN_SUB;
          FUNCT_AND: aluFn = FN_AND;
          FUNCT_OR:  aluFn = FN_OR;
          FUNCT_SLT: aluFn = FN_SLT;
          default:   aluFn = FN_ADD;
        endcase
      end
      default: aluFn = FN_ADD;
    endcase
  end

endmodule

// File: rtl/mcycle_regfile.sv
module mcycle_regfile #(
  parameter int WIDTH = 32,
  parameter int NREGS = 32,
  localparam int AW = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AW-1:0]    rdIdxA,
  input  logic [AW-1:0]    rdIdxB,
  input  logic [AW-1:0]    wrIdx,
  input  logic [WIDTH-1:0] wrData,
  input  logic             wrEn,
  output logic [WIDTH-1:0] rdDataA,
  output logic [WIDTH-1:0] rdDataB
);

  logic [NREGS-1:0][WIDTH-1:0] bank;

  // Entry 0 is hard-wired; it has no storage, so writes to it vanish.
  assign bank[0] = '0;

  for (genvar i = 1; i < NREGS; i++) begin : gEntry
    logic [WIDTH-1:0] cellQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          cellQ <= '0;
      else if (wrEn && wrIdx == AW'(i))   cellQ <= wrData;
    end
    assign bank[i] = cellQ;
  end

  assign rdDataA = bank[rdIdxA];
  assign rdDataB = bank[rdIdxB];

endmodule

// File: rtl/mcycle_core.sv
module mcycle_core
  import mcycle_pkg::*;
#(
  parameter int NREGS = 32,
  localparam int AW = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpCtrl_t         ctl,
  input  logic [XLEN-1:0] memRdata,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  output logic [5:0]      opcode
);

  logic [XLEN-1:0] pcQ, irQ, mdrQ, aQ, bQ, aluOutQ;
  logic [XLEN-1:0] rdA, rdB, wrData, immExt, srcA, srcB, aluY, pcNext;
  logic [AW-1:0]   wrIdx;
  logic            aluZero, pcLoad;
  aluFn_t          aluFn;

  assign immExt = {{(XLEN-16){irQ[15]}}, irQ[15:0]};
  assign wrIdx  = ctl.regDst ? AW'(irQ[15:11]) : AW'(irQ[20:16]);
  assign wrData = ctl.memToReg ? mdrQ : aluOutQ;

  mcycle_regfile #(.WIDTH(XLEN), .NREGS(NREGS)) uRegs (
    .clk     (clk),
    .rstN    (rstN),
    .rdIdxA  (AW'(irQ[25:21])),
    .rdIdxB  (AW'(irQ[20:16])),
    .wrIdx   (wrIdx),
    .wrData  (wrData),
    .wrEn    (ctl.regWrite),
    .rdDataA (rdA),
    .rdDataB (rdB)
  );

  mcycle_alu_dec uDec (
    .aluOp (ctl.aluOp),
    .funct (irQ[5:0]),
    .aluFn (aluFn)
  );

  assign srcA = ctl.aluSrcA ? aQ : pcQ;

  always_comb begin
    unique case (ctl.aluSrcB)
      2'b00:   srcB = bQ;
      2'b01:   srcB = XLEN'(4);
      2'b10:   srcB = immExt;
      default: srcB = immExt << 2;
    endcase
  end

  always_comb begin
    unique case (aluFn)
      FN_ADD:  aluY = srcA + srcB;
      FN_SUB:  aluY = srcA - srcB;
      FN_AND:  aluY = srcA & srcB;
      FN_OR:   aluY = srcA | srcB;
      FN_SLT:  aluY = {{(XLEN-1){1'b0}}, $signed(srcA) < $signed(srcB)};
      default: aluY = srcA + srcB;
    endcase
  end

  assign aluZero = (aluY == '0);

  always_comb begin
    unique case (ctl.pcSource)
      2'b01:   pcNext = aluOutQ;
      2'b10:   pcNext = {pcQ[XLEN-1:XLEN-4], irQ[25:0], 2'b00};
      default: pcNext = aluY;
    endcase
  end

  assign pcLoad = ctl.pcWrite | (ctl.pcWriteCond & aluZero);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ     <= '0;
      irQ     <= '0;
      mdrQ    <= '0;
      aQ      <= '0;
      bQ      <= '0;
      aluOutQ <= '0;
    end else begin
      mdrQ    <= memRdata;
      aQ      <= rdA;
      bQ      <= rdB;
      aluOutQ <= aluY;
      if (ctl.irWrite) irQ <= memRdata;
      if (pcLoad)      pcQ <= pcNext;
    end
  end

  assign memAddr  = ctl.iorD ? aluOutQ : pcQ;
  assign memWdata = bQ;
  assign opcode   = irQ[31:26];

endmodule

// File: rtl/mcycle_datapath.sv
module mcycle_datapath
  import mcycle_pkg::*;
#(
  parameter int NREGS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pcWrite,
  input  logic        pcWriteCond,
  input  logic        iorD,
  input  logic        irWrite,
  input  logic        regDst,
  input  logic        memToReg,
  input  logic        regWrite,
  input  logic        aluSrcA,
  input  logic [1:0]  aluSrcB,
  input  logic [1:0]  aluOp,
  input  logic [1:0]  pcSource,
  input  logic [31:0] memRdata,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  output logic [5:0]  opcode
);

  dpCtrl_t ctl;

  always_comb begin
    ctl.pcWrite     = pcWrite;
    ctl.pcWriteCond = pcWriteCond;
    ctl.iorD        = iorD;
    ctl.irWrite     = irWrite;
    ctl.regDst      = regDst;
    ctl.memToReg    = memToReg;
    ctl.regWrite    = regWrite;
    ctl.aluSrcA     = aluSrcA;
    ctl.aluSrcB     = aluSrcB;
    ctl.aluOp       = aluOp;
    ctl.pcSource    = pcSource;
  end

  mcycle_core #(.NREGS(NREGS)) uCore (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .opcode   (opcode)
  );

endmodule

// File: rtl/mcycle_datapath_checks.sv
module mcycle_datapath_checks (
  input logic        clk,
  input logic        rstN,
  input logic        pcWrite,
  input logic        pcWriteCond,
  input logic        iorD,
  input logic        irWrite,
  input logic        aluSrcA,
  input logic [1:0]  aluSrcB,
  input logic [1:0]  aluOp,
  input logic [1:0]  pcSource,
  input logic [31:0] memAddr,
  input logic [31:0] memWdata,
  input logic [5:0]  opcode
);

  // R1: first edge after reset release still sees cleared state
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (memAddr == 32'd0 && memWdata == 32'd0 && opcode == 6'd0));

  // R2: a full fetch strobe set advances the PC by 4
  p_fetch_inc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pcWrite && pcSource == 2'b00 && !aluSrcA && aluSrcB == 2'b01 &&
     aluOp == 2'b00 && !iorD)
    |=> (iorD || memAddr == $past(memAddr) + 32'd4));

  // R3: instruction register holds without its enable
  p_ir_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !irWrite |=> $stable(opcode));

  // R9: no PC load strobe means the PC holds
  p_pc_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!pcWrite && !pcWriteCond && !iorD) |=> (iorD || $stable(memAddr)));

  // R9: jump keeps the PC's top nibble and is word aligned
  p_jump_align_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pcWrite && pcSource == 2'b10 && !iorD)
    |=> (iorD || (memAddr[31:28] == $past(memAddr[31:28]) && memAddr[1:0] == 2'b00)));

endmodule

bind mcycle_datapath mcycle_datapath_checks uChecks (
  .clk         (clk),
  .rstN        (rstN),
  .pcWrite     (pcWrite),
  .pcWriteCond (pcWriteCond),
  .iorD        (iorD),
  .irWrite     (irWrite),
  .aluSrcA     (aluSrcA),
  .aluSrcB     (aluSrcB),
  .aluOp       (aluOp),
  .pcSource    (pcSource),
  .memAddr     (memAddr),
  .memWdata    (memWdata),
  .opcode      (opcode)
);

// File: tb/mcycle_datapath_test.sv
`timescale 1ns/1ps
module mcycle_datapath_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pcWrite, pcWriteCond, iorD, irWrite, regDst, memToReg, regWrite, aluSrcA;
  logic [1:0]  aluSrcB, aluOp, pcSource;
  logic [31:0] memRdata, memAddr, memWdata;
  logic [5:0]  opcode;
  logic        memWr;

  logic [31:0] mem [256];
  logic [31:0] mRegs [32];
  logic [31:0] mPc;
  int          errors = 0;
  int          checks = 0;

  always #4 clk = ~clk;

  mcycle_datapath uut (
    .clk(clk), .rstN(rstN), .pcWrite(pcWrite), .pcWriteCond(pcWriteCond),
    .iorD(iorD), .irWrite(irWrite), .regDst(regDst), .memToReg(memToReg),
    .regWrite(regWrite), .aluSrcA(aluSrcA), .aluSrcB(aluSrcB), .aluOp(aluOp),
    .pcSource(pcSource), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .opcode(opcode)
  );

  assign memRdata = mem[memAddr[9:2]];
  always @(posedge clk) if (memWr) mem[memAddr[9:2]] <= memWdata;

  function automatic logic [31:0] encR(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
    return {6'b000000, rs, rt, rd, 5'b00000, fn};
  endfunction
  function automatic logic [31:0] encI(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] expAlu(logic [5:0] fn, logic [31:0] a, logic [31:0] b);
    case (fn)
      6'b100000: return a + b;
      6'b100010: return a - b;
      6'b100100: return a & b;
      6'b100101: return a | b;
      6'b101010: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default:   return a + b;
    endcase
  endfunction

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic clearCtl();
    pcWrite = 0; pcWriteCond = 0; iorD = 0; irWrite = 0; regDst = 0; memToReg = 0;
    regWrite = 0; aluSrcA = 0; aluSrcB = 2'b00; aluOp = 2'b00; pcSource = 2'b00; memWr = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic peek(input logic sel, output logic [31:0] v);
    iorD = sel;
    #1;
    v = memAddr;
  endtask

  // One instruction through all of its steps, checking each step.
  task automatic runInstr();
    logic [31:0] ins, v, sx, ea, exp;
    logic [4:0]  rs, rt, rd;
    ins = mem[mPc[9:2]];
    rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    sx = {{16{ins[15]}}, ins[15:0]};
    // fetch
    clearCtl(); irWrite = 1; aluSrcB = 2'b01; pcWrite = 1; tick(); clearCtl();
    check("R2 opcode after fetch", {26'd0, opcode}, {26'd0, ins[31:26]});
    mPc = mPc + 4;
    peek(1'b0, v); check("R2 pc plus 4", v, mPc);
    // decode
    clearCtl(); aluSrcB = 2'b11; tick(); clearCtl();
    check("R3 opcode held in decode", {26'd0, opcode}, {26'd0, ins[31:26]});
    peek(1'b1, v); check("R6 branch target in ALUOut", v, mPc + (sx << 2));
    check("R4 operand B from rt", memWdata, mRegs[rt]);
    case (ins[31:26])
      6'b000000: begin
        clearCtl(); aluSrcA = 1; aluOp = 2'b10; tick(); clearCtl();
        exp = expAlu(ins[5:0], mRegs[rs], mRegs[rt]);
        peek(1'b1, v); check($sformatf("R7 funct %b result", ins[5:0]), v, exp);
        clearCtl(); regDst = 1; regWrite = 1; tick(); clearCtl();
        if (rd != 0) mRegs[rd] = exp;
      end
      6'b100011: begin
        ea = mRegs[rs] + sx;
        clearCtl(); aluSrcA = 1; aluSrcB = 2'b10; tick(); clearCtl();
        peek(1'b1, v); check("R8 load address add", v, ea);
        clearCtl(); iorD = 1; tick(); clearCtl();
        check("R3 opcode held in memory step", {26'd0, opcode}, {26'd0, ins[31:26]});
        clearCtl(); memToReg = 1; regWrite = 1; tick(); clearCtl();
        if (rt != 0) mRegs[rt] = mem[ea[9:2]];
      end
      6'b101011: begin
        ea = mRegs[rs] + sx;
        clearCtl(); aluSrcA = 1; aluSrcB = 2'b10; tick(); clearCtl();
        peek(1'b1, v); check("R6 store address", v, ea);
        clearCtl(); iorD = 1; memWr = 1; tick(); clearCtl();
        check("R10 store data from B", mem[ea[9:2]], mRegs[rt]);
      end
      6'b000100: begin
        exp = mPc + (sx << 2);
        clearCtl(); aluSrcA = 1; aluOp = 2'b01; pcSource = 2'b01; pcWriteCond = 1;
        tick(); clearCtl();
        if (mRegs[rs] == mRegs[rt]) mPc = exp;
        peek(1'b0, v); check("R9 conditional PC", v, mPc);
        peek(1'b1, v); check("R8 forced subtract", v, mRegs[rs] - mRegs[rt]);
      end
      6'b000010: begin
        clearCtl(); pcWrite = 1; pcSource = 2'b10; tick(); clearCtl();
        mPc = {mPc[31:28], ins[25:0], 2'b00};
        peek(1'b0, v); check("R9 jump target", v, mPc);
      end
      default: begin
        errors++; checks++;
        $display("FAIL R2 unexpected opcode actual=%b expected=known", ins[31:26]);
      end
    endcase
  endtask

  task automatic testReset();
    logic [31:0] v;
    peek(1'b0, v); check("R1 pc after reset", v, 32'd0);
    peek(1'b1, v); check("R1 ALUOut after reset", v, 32'd0);
    check("R1 B after reset", memWdata, 32'd0);
    check("R1 opcode after reset", {26'd0, opcode}, 32'd0);
    iorD = 0;
  endtask

  task automatic testLoads();
    runInstr(); runInstr();
  endtask

  task automatic testAluOps();
    for (int i = 0; i < 7; i++) runInstr();
  endtask

  task automatic testStore();
    runInstr();
    check("R5 add result written to rd", mem[32'h108 >> 2], 32'hFFFF_FFF7);
  endtask

  task automatic testBranches();
    runInstr();
    check("R9 branch not taken", mPc, 32'd44);
    runInstr();
    check("R9 branch taken", mPc, 32'd60);
  endtask

  task automatic testJumpAndNegOffset();
    runInstr();
    runInstr();
    runInstr();
    check("R4 r9 loaded through negative offset", mRegs[9], mem[4]);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clearCtl();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0000_0000;
    for (int i = 0; i < 32; i++) mRegs[i] = 32'd0;
    mPc = 32'd0;
    mem[0]  = encI(6'b100011, 5'd0, 5'd1, 16'h0100);
    mem[1]  = encI(6'b100011, 5'd0, 5'd2, 16'h0124);
    mem[2]  = encR(5'd1, 5'd2, 5'd3, 6'b100000);
    mem[3]  = encR(5'd1, 5'd2, 5'd4, 6'b100010);
    mem[4]  = encR(5'd1, 5'd2, 5'd5, 6'b100100);
    mem[5]  = encR(5'd1, 5'd2, 5'd6, 6'b100101);
    mem[6]  = encR(5'd2, 5'd1, 5'd7, 6'b101010);
    mem[7]  = encR(5'd1, 5'd2, 5'd8, 6'b101010);
    mem[8]  = encR(5'd1, 5'd1, 5'd0, 6'b100000);
    mem[9]  = encI(6'b101011, 5'd0, 5'd3, 16'h0108);
    mem[10] = encI(6'b000100, 5'd1, 5'd2, 16'h0005);
    mem[11] = encI(6'b000100, 5'd5, 5'd0, 16'h0003);
    mem[12] = 32'hFFFF_FFFF;
    mem[15] = {6'b000010, 26'h20};
    mem[32] = encI(6'b100011, 5'd4, 5'd9, 16'hFFF9);
    mem[33] = encR(5'd0, 5'd9, 5'd10, 6'b100101);
    mem[34] = encR(5'd0, 5'd0, 5'd11, 6'b100000);
    mem[32'h100 >> 2] = 32'h0000_0007;
    mem[32'h124 >> 2] = 32'hFFFF_FFF0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    testReset();
    testLoads();
    testAluOps();
    check("R7 signed slt true", mRegs[7], 32'd1);
    check("R7 signed slt false", mRegs[8], 32'd0);
    check("R4 write to entry 0 ignored", mRegs[0], 32'd0);
    testStore();
    testBranches();
    testJumpAndNegOffset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule